// File: doc/BRIEF.md
# Flow Hash Queue Selector

The block picks a receive queue for each parsed frame so that all frames of one flow land on the same queue while different flows spread over a range of queues. From the frame descriptor it forms a flow key out of the IPv4 source and destination addresses and the TCP/UDP source and destination ports. A field the parser did not find is replaced by a configured default word. The key is folded into a 64-bit hash. A right shift then selects a 24-bit window of that hash, the window is masked down to a power-of-two range, and the result is ORed onto an aligned base queue id.

Frames enter through a valid/ready handshake at one per cycle and leave through a second valid/ready pair after a fixed three-stage pipeline. The configuration is sampled when a frame is accepted, so it may change between frames without disturbing frames already in flight. A symmetric option makes both directions of a connection map to the same queue. When the scheme is disabled, every frame goes straight to the base queue. An illegal configuration raises a sticky error flag and drops the offending frame. A free-running counter reports how many frames have been accepted.

Top module: `flow_hash_qsel`

## Requirements
- R1: A frame is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 whenever `out_valid` is 0 or `out_ready` is 1. With the output path free, the result of a frame accepted on edge k is presented on `out_valid`/`out_qid` after edge k+2, and not before.
- R2: When `in_has_ip` is 0, both key addresses take the value of `cfg_dflt_addr` (intended default 0x0A0A0A0A), and the frame's address inputs have no effect on the queue id.
- R3: When `in_has_l4` is 0, both key ports take the value of `cfg_dflt_port` (intended default 0x0B0B), and the frame's port inputs have no effect on the queue id.
- R4: The hash is computed from key addresses A0, A1 and ports P0, P1 as follows. Let k0 = {A0,A1} and k1 = {P0,P1,P1,P0}. Then h = k0 ^ rotl64(k1,23) ^ 0x9E3779B97F4A7C15. Next h ^= h>>29, h ^= h<<17, h ^= h>>37, and finally h ^= {h[31:0],h[63:32]}. Without symmetric mode, A0/A1 are the source/destination addresses and P0/P1 are the source/destination ports.
- R5: The hash is shifted right by `cfg_shift` (0..63), and the 24 least significant bits of the shifted value are kept.
- R6: With `cfg_enable` = 1, `out_qid` = `cfg_base` | (kept bits & (`cfg_size` − 1)); `cfg_size` = 1 therefore yields the base.
- R7: With `cfg_enable` = 0, hashing is bypassed and `out_qid` equals `cfg_base`.
- R8: With `cfg_symmetric` = 1, A0 is the numerically smaller address and A1 the larger, and P0/P1 are ordered the same way. A frame and its source/destination swapped twin therefore get the same queue id.
- R9: A frame accepted while `cfg_base` is 0, or while `cfg_enable` is 1 and `cfg_size` is zero, not a power of two, or not aligned with `cfg_base`, produces no output. From the next cycle `cfg_err` is 1 and stays 1 until reset.
- R10: `frame_cnt` is 0 after reset and increases by one on every accepted frame, including dropped ones.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_qid` holds its value on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Frame descriptor valid |
| in_ready | output | 1 | Block can take a descriptor this cycle |
| in_src_ip | input | 32 | IPv4 source address |
| in_dst_ip | input | 32 | IPv4 destination address |
| in_src_port | input | 16 | L4 source port |
| in_dst_port | input | 16 | L4 destination port |
| in_has_ip | input | 1 | Frame carries an IPv4 header |
| in_has_l4 | input | 1 | Frame carries a TCP/UDP header |
| cfg_enable | input | 1 | Scheme enable; 0 bypasses hashing |
| cfg_symmetric | input | 1 | Order-independent key |
| cfg_base | input | 24 | Base queue id, aligned to the range |
| cfg_size | input | 25 | Range size, a power of two up to 2^24 |
| cfg_shift | input | 6 | Right shift applied to the hash |
| cfg_dflt_addr | input | 32 | Substitute for absent addresses |
| cfg_dflt_port | input | 16 | Substitute for absent ports |
| out_valid | output | 1 | Queue id valid |
| out_ready | input | 1 | Downstream takes the queue id |
| out_qid | output | 24 | Selected queue id |
| cfg_err | output | 1 | Sticky configuration error |
| frame_cnt | output | 32 | Count of accepted frames |

## Verification
A result held at the output under back-pressure and a new frame waiting at the input fall in the same cycle. The stall must freeze the held queue id, drop `in_ready`, and keep the waiting frame until it is taken. The bench provokes this by streaming descriptors back to back while `out_ready` follows a repeating two-on, one-off pattern. It judges the outcome by checking that every stalled output is unchanged one cycle later and that the scoreboard receives every expected queue id exactly once and in order. A dropped frame under a bad configuration is judged by the absence of any unexpected output, together with the sticky flag and the frame count.

// File: rtl/fhq_pkg.sv
// Shared widths, the per-frame configuration snapshot and the flow hash.
// Assumes 32-bit IPv4 addresses, 16-bit L4 ports and a 64-bit hash.
package fhq_pkg;
    localparam int ADDR_W  = 32;
    localparam int PORT_W  = 16;
    localparam int HASH_W  = 64;
    localparam int QID_W   = 24;
    localparam int SHIFT_W = $clog2(HASH_W);
    localparam int SIZE_W  = QID_W + 1;
    localparam int CNT_W   = 32;
    localparam int ROT_K   = 23;
    localparam logic [HASH_W-1:0] MIX_SALT = 64'h9E3779B97F4A7C15;

    // Configuration captured with a frame and carried down the pipeline.
    typedef struct packed {
        logic               en;
        logic               err;
        logic [QID_W-1:0]   base;
        logic [QID_W-1:0]   mask;
        logic [SHIFT_W-1:0] shift;
    } fhq_cfg_t;

    // Deterministic 64-bit mixing of the ordered flow key.
    function automatic logic [HASH_W-1:0] fhq_mix(
        input logic [ADDR_W-1:0] a0,
        input logic [ADDR_W-1:0] a1,
        input logic [PORT_W-1:0] p0,
        input logic [PORT_W-1:0] p1
    );
        logic [HASH_W-1:0] k0;
        logic [HASH_W-1:0] k1;
        logic [HASH_W-1:0] h;
        k0 = {a0, a1};
        k1 = {p0, p1, p1, p0};
        h  = k0 ^ {k1[HASH_W-1-ROT_K:0], k1[HASH_W-1:HASH_W-ROT_K]} ^ MIX_SALT;
        h  = h ^ (h >> 29);
        h  = h ^ (h << 17);
        h  = h ^ (h >> 37);
        h  = h ^ {h[HASH_W/2-1:0], h[HASH_W-1:HASH_W/2]};
        return h;
    endfunction
endpackage

// File: rtl/fhq_key_stage.sv
// Stage 1: substitutes default words for absent fields, optionally orders
// each address and port pair, and registers the key with its config.
// Assumes the caller loads it only when the pipeline advances.
module fhq_key_stage
    import fhq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] src_ip,
    input  logic [ADDR_W-1:0] dst_ip,
    input  logic [PORT_W-1:0] src_port,
    input  logic [PORT_W-1:0] dst_port,
    input  logic              has_ip,
    input  logic              has_l4,
    input  logic              symmetric,
    input  logic [ADDR_W-1:0] dflt_addr,
    input  logic [PORT_W-1:0] dflt_port,
    input  fhq_cfg_t          cfg_in,
    output logic              k_valid,
    output logic [ADDR_W-1:0] k_a0,
    output logic [ADDR_W-1:0] k_a1,
    output logic [PORT_W-1:0] k_p0,
    output logic [PORT_W-1:0] k_p1,
    output fhq_cfg_t          k_cfg
);
    logic [ADDR_W-1:0] a0_d, a1_d, sa, da;
    logic [PORT_W-1:0] p0_d, p1_d, sp, dp;
    logic              sym_q;

    // Pick frame or default fields, then order pairs in symmetric mode.
    always_comb begin
        sa = has_ip ? src_ip   : dflt_addr;
        da = has_ip ? dst_ip   : dflt_addr;
        sp = has_l4 ? src_port : dflt_port;
        dp = has_l4 ? dst_port : dflt_port;
        if (symmetric && (sa > da)) begin
            a0_d = da;
            a1_d = sa;
        end else begin
            a0_d = sa;
            a1_d = da;
        end
        if (symmetric && (sp > dp)) begin
            p0_d = dp;
            p1_d = sp;
        end else begin
            p0_d = sp;
            p1_d = dp;
        end
    end

    // Register the key and configuration when the pipeline moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_valid <= 1'b0;
            k_a0    <= '0;
            k_a1    <= '0;
            k_p0    <= '0;
            k_p1    <= '0;
            k_cfg   <= '0;
            sym_q   <= 1'b0;
        end else if (adv) begin
            k_valid <= in_valid;
            if (in_valid) begin
                k_a0  <= a0_d;
                k_a1  <= a1_d;
                k_p0  <= p0_d;
                k_p1  <= p1_d;
                k_cfg <= cfg_in;
                sym_q <= symmetric;
            end
        end
    end

    AST_SYM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (k_valid && sym_q) |-> ((k_a0 <= k_a1) && (k_p0 <= k_p1))); // R8
endmodule

// File: rtl/fhq_hash_stage.sv
// Stage 2: folds the registered key into a 64-bit hash and registers it.
// Assumes the key stage holds its outputs while the pipeline is stalled.
module fhq_hash_stage
    import fhq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              k_valid,
    input  logic [ADDR_W-1:0] k_a0,
    input  logic [ADDR_W-1:0] k_a1,
    input  logic [PORT_W-1:0] k_p0,
    input  logic [PORT_W-1:0] k_p1,
    input  fhq_cfg_t          k_cfg,
    output logic              h_valid,
    output logic [HASH_W-1:0] h_val,
    output fhq_cfg_t          h_cfg
);
    logic [HASH_W-1:0] hash_d;

    // Combinational mix of the ordered key.
    always_comb hash_d = fhq_mix(k_a0, k_a1, k_p0, k_p1);

    // Register the hash and pass the configuration along.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_valid <= 1'b0;
            h_val   <= '0;
            h_cfg   <= '0;
        end else if (adv) begin
            h_valid <= k_valid;
            if (k_valid) begin
                h_val <= hash_d;
                h_cfg <= k_cfg;
            end
        end
    end
endmodule

// File: rtl/fhq_qid_stage.sv
// Stage 3: selects a 24-bit hash window, masks it to the range, adds the
// base, and holds the result for the output handshake. Frames flagged
// with a configuration error are dropped here.
module fhq_qid_stage
    import fhq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              h_valid,
    input  logic [HASH_W-1:0] h_val,
    input  fhq_cfg_t          h_cfg,
    output logic              q_valid,
    output logic [QID_W-1:0]  q_id
);
    logic [QID_W-1:0] win;
    logic [QID_W-1:0] qid_d;

    // Shift, mask and combine with the base; bypass when disabled.
    always_comb begin
        win   = QID_W'(h_val >> h_cfg.shift);
        qid_d = h_cfg.en ? (h_cfg.base | (win & h_cfg.mask)) : h_cfg.base;
    end

    // Output register with drop of errored frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_id    <= '0;
        end else if (adv) begin
            q_valid <= h_valid && !h_cfg.err;
            if (h_valid) q_id <= qid_d;
        end
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && !adv) |=> (q_valid && $stable(q_id))); // R11
endmodule

// File: rtl/flow_hash_qsel.sv
// Top: per-frame flow hash queue selector, three-stage pipeline, one frame
// per cycle. The whole pipeline stalls while the output is held. The
// configuration is checked and snapshotted when a frame is accepted.
module flow_hash_qsel
    import fhq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [ADDR_W-1:0]  in_src_ip,
    input  logic [ADDR_W-1:0]  in_dst_ip,
    input  logic [PORT_W-1:0]  in_src_port,
    input  logic [PORT_W-1:0]  in_dst_port,
    input  logic               in_has_ip,
    input  logic               in_has_l4,
    input  logic               cfg_enable,
    input  logic               cfg_symmetric,
    input  logic [QID_W-1:0]   cfg_base,
    input  logic [SIZE_W-1:0]  cfg_size,
    input  logic [SHIFT_W-1:0] cfg_shift,
    input  logic [ADDR_W-1:0]  cfg_dflt_addr,
    input  logic [PORT_W-1:0]  cfg_dflt_port,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [QID_W-1:0]   out_qid,
    output logic               cfg_err,
    output logic [CNT_W-1:0]   frame_cnt
);
    logic              adv, accept, size_bad, bad_cfg;
    logic [QID_W-1:0]  mask;
    fhq_cfg_t          cfg_now, k_cfg, h_cfg;
    logic              k_valid, h_valid;
    logic [ADDR_W-1:0] k_a0, k_a1;
    logic [PORT_W-1:0] k_p0, k_p1;
    logic [HASH_W-1:0] h_val;

    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;
    assign accept   = in_valid && adv;

    // Validate the live configuration and build its snapshot.
    always_comb begin
        mask     = QID_W'(cfg_size - SIZE_W'(1));
        size_bad = (cfg_size == '0) ||
                   ((cfg_size & (cfg_size - SIZE_W'(1))) != '0) ||
                   ((cfg_base & mask) != '0);
        bad_cfg  = (cfg_base == '0) || (cfg_enable && size_bad);
        cfg_now.en    = cfg_enable;
        cfg_now.err   = bad_cfg;
        cfg_now.base  = cfg_base;
        cfg_now.mask  = mask;
        cfg_now.shift = cfg_shift;
    end

    // Sticky error flag and accepted-frame counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err   <= 1'b0;
            frame_cnt <= '0;
        end else if (accept) begin
            frame_cnt <= frame_cnt + CNT_W'(1);
            if (bad_cfg) cfg_err <= 1'b1;
        end
    end

    fhq_key_stage u_key (
        .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(in_valid),
        .src_ip(in_src_ip), .dst_ip(in_dst_ip),
        .src_port(in_src_port), .dst_port(in_dst_port),
        .has_ip(in_has_ip), .has_l4(in_has_l4),
        .symmetric(cfg_symmetric), .dflt_addr(cfg_dflt_addr),
        .dflt_port(cfg_dflt_port), .cfg_in(cfg_now),
        .k_valid(k_valid), .k_a0(k_a0), .k_a1(k_a1),
        .k_p0(k_p0), .k_p1(k_p1), .k_cfg(k_cfg)
    );

    fhq_hash_stage u_hash (
        .clk(clk), .rst_n(rst_n), .adv(adv), .k_valid(k_valid),
        .k_a0(k_a0), .k_a1(k_a1), .k_p0(k_p0), .k_p1(k_p1), .k_cfg(k_cfg),
        .h_valid(h_valid), .h_val(h_val), .h_cfg(h_cfg)
    );

    fhq_qid_stage u_qid (
        .clk(clk), .rst_n(rst_n), .adv(adv), .h_valid(h_valid),
        .h_val(h_val), .h_cfg(h_cfg),
        .q_valid(out_valid), .q_id(out_qid)
    );

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R9
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(frame_cnt)); // R10
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (frame_cnt == $past(frame_cnt) + CNT_W'(1))); // R10
    AST_QID_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_qid != '0)); // R6
endmodule

// File: tb/flow_hash_qsel_tb.sv
// Scoreboard bench: the driver pushes expected queue ids, the monitor pops
// and compares them as the design delivers results.
module flow_hash_qsel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_src_ip = '0, in_dst_ip = '0;
    logic [15:0] in_src_port = '0, in_dst_port = '0;
    logic        in_has_ip = 1'b0, in_has_l4 = 1'b0;
    logic        cfg_enable = 1'b1, cfg_symmetric = 1'b0;
    logic [23:0] cfg_base = 24'h000100;
    logic [24:0] cfg_size = 25'd16;
    logic [5:0]  cfg_shift = '0;
    logic [31:0] cfg_dflt_addr = 32'h0A0A0A0A;
    logic [15:0] cfg_dflt_port = 16'h0B0B;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [23:0] out_qid;
    logic        cfg_err;
    logic [31:0] frame_cnt;

    int unsigned exp_q[$];
    string       tag_q[$];
    int          errors = 0;
    int          checks = 0;
    int          sent = 0;
    int          bp_mode = 0;
    int          bp_cnt = 0;
    logic        prev_stall = 1'b0;
    logic [23:0] prev_qid = '0;
    bit          done = 0;

    flow_hash_qsel u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_src_ip(in_src_ip), .in_dst_ip(in_dst_ip),
        .in_src_port(in_src_port), .in_dst_port(in_dst_port),
        .in_has_ip(in_has_ip), .in_has_l4(in_has_l4),
        .cfg_enable(cfg_enable), .cfg_symmetric(cfg_symmetric),
        .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_shift(cfg_shift),
        .cfg_dflt_addr(cfg_dflt_addr), .cfg_dflt_port(cfg_dflt_port),
        .out_valid(out_valid), .out_ready(out_ready), .out_qid(out_qid),
        .cfg_err(cfg_err), .frame_cnt(frame_cnt)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Hash as written in R4.
    function automatic logic [63:0] spec_hash(input logic [31:0] a0, a1, input logic [15:0] p0, p1);
        logic [63:0] k0, k1, h;
        k0 = {a0, a1};
        k1 = {p0, p1, p1, p0};
        h  = k0 ^ ((k1 << 23) | (k1 >> 41)) ^ 64'h9E3779B97F4A7C15;
        h  = h ^ (h >> 29);
        h  = h ^ (h << 17);
        h  = h ^ (h >> 37);
        h  = h ^ ((h << 32) | (h >> 32));
        return h;
    endfunction

    function automatic logic [23:0] spec_qid(input logic [31:0] sa, da, input logic [15:0] sp, dp,
                                             input logic hi, hl);
        logic [31:0] a0, a1, t;
        logic [15:0] p0, p1, u;
        logic [63:0] h;
        logic [23:0] win;
        a0 = hi ? sa : cfg_dflt_addr;   // R2
        a1 = hi ? da : cfg_dflt_addr;
        p0 = hl ? sp : cfg_dflt_port;   // R3
        p1 = hl ? dp : cfg_dflt_port;
        if (cfg_symmetric) begin        // R8
            if (a0 > a1) begin t = a0; a0 = a1; a1 = t; end
            if (p0 > p1) begin u = p0; p0 = p1; p1 = u; end
        end
        if (!cfg_enable) return cfg_base; // R7
        h   = spec_hash(a0, a1, p0, p1);
        win = 24'(h >> cfg_shift);        // R5
        return cfg_base | (win & 24'(cfg_size - 25'd1)); // R6
    endfunction

    function automatic bit spec_bad();
        logic [24:0] m;
        m = cfg_size - 25'd1;
        return (cfg_base == 0) ||
               (cfg_enable && ((cfg_size == 0) || ((cfg_size & m) != 0) ||
                               ((cfg_base & 24'(m)) != 0)));
    endfunction

    // Driver: present a frame until accepted, then log the expectation.
    task automatic send(input logic [31:0] sa, da, input logic [15:0] sp, dp,
                        input logic hi, hl, input string tag);
        bit acc;
        in_valid = 1'b1; in_src_ip = sa; in_dst_ip = da;
        in_src_port = sp; in_dst_port = dp; in_has_ip = hi; in_has_l4 = hl;
        do begin
            @(negedge clk); acc = in_ready;
            @(posedge clk); #1;
        end while (!acc);
        sent++;
        if (!spec_bad()) begin
            exp_q.push_back(int'(spec_qid(sa, da, sp, dp, hi, hl)));
            tag_q.push_back(tag);
        end
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic drain();
        int k = 0;
        while ((exp_q.size() != 0) && (k < 300)) begin idle(1); k++; end
        idle(4);
        check(exp_q.size() == 0, "R1 drain", exp_q.size(), 0);
    endtask

    // Output-ready pattern generator.
    initial forever begin
        @(posedge clk); #1;
        if (bp_mode != 0) begin
            out_ready = ((bp_cnt % 3) != 0);
            bp_cnt++;
        end else out_ready = 1'b1;
    end

    // Monitor: compare deliveries and check held results under stall.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                check(out_valid == 1'b1, "R11 valid held", out_valid, 1);
                check(out_qid == prev_qid, "R11 qid held", out_qid, prev_qid);
            end
            prev_stall = out_valid && !out_ready;
            prev_qid   = out_qid;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected output", out_qid, 0);
                end else begin
                    check(out_qid == 24'(exp_q[0]), tag_q[0], out_qid, exp_q[0]);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end
        end
    end

    initial begin
        int wd = 0;
        while (!done && wd < 150000) begin @(posedge clk); wd++; end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=finish", wd);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        @(negedge clk);
        check(out_valid == 0, "R1 reset out_valid", out_valid, 0);
        check(frame_cnt == 0, "R10 reset count", frame_cnt, 0);
        check(cfg_err == 0, "R9 reset err", cfg_err, 0);
        check(in_ready == 1, "R1 reset in_ready", in_ready, 1);
        @(posedge clk); #1;

        // R1 latency with a free output path.
        send(32'hC0A80001, 32'hC0A80002, 16'd1234, 16'd80, 1, 1, "R4 hash qid");
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 0, "R1 not early", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1, "R1 latency", out_valid, 1);
        idle(3);

        // R4/R6 varied flows, size 16.
        for (int i = 0; i < 8; i++)
            send(32'h0A000000 + i * 32'h01010101, 32'hAC100000 ^ i, 16'(1000 + i * 7), 16'(443 - i), 1, 1, "R6 masked qid");
        // R5 shifted window with a wide range.
        cfg_shift = 6'd40; cfg_size = 25'd1024; cfg_base = 24'h000400;
        for (int i = 0; i < 6; i++)
            send(32'h12345678 + i, 32'h9ABCDEF0 - i, 16'(i * 311), 16'(53), 1, 1, "R5 shifted qid");
        cfg_shift = 6'd63;
        send(32'hFFFFFFFF, 32'h00000001, 16'hFFFF, 16'h0001, 1, 1, "R5 top shift");
        cfg_shift = 6'd0;
        // R6 size one gives the base.
        cfg_size = 25'd1; cfg_base = 24'h00ABCD;
        send(32'h01020304, 32'h05060708, 16'd9, 16'd10, 1, 1, "R6 size one");
        cfg_size = 25'h1000000; cfg_base = 24'h000000 | 24'h0;
        cfg_size = 25'd256; cfg_base = 24'h123400;
        // R2 absent IPv4: addresses must not matter.
        send(32'h11111111, 32'h22222222, 16'd5000, 16'd6000, 0, 1, "R2 default addr");
        send(32'h33333333, 32'h44444444, 16'd5000, 16'd6000, 0, 1, "R2 addr ignored");
        cfg_dflt_addr = 32'h0C0C0C0C;
        send(32'h33333333, 32'h44444444, 16'd5000, 16'd6000, 0, 1, "R2 new default");
        // R3 absent L4: ports must not matter.
        send(32'h0A0B0C0D, 32'h01020304, 16'd1, 16'd2, 1, 0, "R3 default port");
        send(32'h0A0B0C0D, 32'h01020304, 16'd777, 16'd888, 1, 0, "R3 port ignored");
        send(32'h0A0B0C0D, 32'h01020304, 16'd777, 16'd888, 0, 0, "R3 both absent");
        drain();
        check(out_qid[23:8] == 16'h1234, "R6 base kept", out_qid[23:8], 16'h1234);

        // R8 symmetric: a frame and its swapped twin.
        cfg_symmetric = 1'b1;
        send(32'hC6336401, 32'h0A000005, 16'd40000, 16'd22, 1, 1, "R8 forward");
        send(32'h0A000005, 32'hC6336401, 16'd22, 16'd40000, 1, 1, "R8 reverse");
        drain();
        check(spec_qid(32'hC6336401, 32'h0A000005, 16'd40000, 16'd22, 1, 1) ==
              spec_qid(32'h0A000005, 32'hC6336401, 16'd22, 16'd40000, 1, 1),
              "R8 model twin", 0, 0);
        cfg_symmetric = 1'b0;

        // R7 disabled scheme goes to the base.
        cfg_enable = 1'b0; cfg_size = 25'd3; cfg_base = 24'h000777;
        send(32'hDEADBEEF, 32'hCAFEF00D, 16'd1, 16'd2, 1, 1, "R7 bypass");
        send(32'h00000000, 32'hFFFFFFFF, 16'd3, 16'd4, 1, 1, "R7 bypass2");
        drain();
        check(out_qid == 24'h000777, "R7 base out", out_qid, 24'h000777);
        check(cfg_err == 0, "R9 no error when disabled", cfg_err, 0);
        cfg_enable = 1'b1; cfg_size = 25'd64; cfg_base = 24'h000040;

        // R11 back-pressure with back-to-back frames.
        bp_mode = 1;
        for (int i = 0; i < 30; i++)
            send(32'h50000000 + i * 13, 32'h60000000 + i, 16'(i), 16'(i * 3), 1, 1, "R11 stream qid");
        drain();
        bp_mode = 0;
        idle(2);

        // R9 bad base: frame dropped, flag sticky.
        check(cfg_err == 0, "R9 clean before", cfg_err, 0);
        cfg_base = 24'h0;
        send(32'h1, 32'h2, 16'd3, 16'd4, 1, 1, "R9 dropped");
        idle(1);
        @(negedge clk);
        check(cfg_err == 1, "R9 flag set", cfg_err, 1);
        @(posedge clk); #1;
        cfg_base = 24'h000040; cfg_size = 25'd48;
        send(32'h5, 32'h6, 16'd7, 16'd8, 1, 1, "R9 bad size");
        cfg_size = 25'd64;
        send(32'h5, 32'h6, 16'd7, 16'd8, 1, 1, "R9 good after");
        drain();
        check(cfg_err == 1, "R9 sticky", cfg_err, 1);
        check(frame_cnt == 32'(sent), "R10 frame count", frame_cnt, sent);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule